// File: doc/BRIEF.md
# Management Frame Host Port

This block connects a management CPU to the frame path of a switch through a byte-wide register window. To send a frame into the switch, the host opens it by writing the receive-control register. It then writes the payload one byte at a time into the data register and closes the frame with a second control write. Only a closed frame is offered to the fabric. The fabric reads the frame by address and hands the buffer back with a one-cycle done pulse.

In the other direction, the fabric pushes frames byte by byte into a small queue of frame slots. The host drains the oldest frame through the same data register. The transmit-control and length registers tell the host how long the current frame is, and whether the next byte is the first or the last one.

Two ready outputs let the host avoid stalling its bus. One says that a complete frame is waiting. The other says that a frame of any legal length can be written. While the DMA-select input is high, the address pins are ignored and every access is steered to the data register. A DMA engine can then move a whole frame without setting up addresses.

Top module: `mfp_host_port`

## Requirements
- R1: After reset, rx_ready is 1, tx_ready, fab_rx_valid and fab_tx_full are 0, the receive-control register (index 0) reads 0x01, and the transmit-control (index 1) and length (index 3) registers read 0x00.
- R2: A host write to index 0 with bit 0 set opens a frame and clears the write pointer, unless a closed frame is still held. A restart while a frame is open discards the bytes written so far. rx_ready is 0 from the opening write until the buffer is freed.
- R3: Host writes to the data register (index 2) while a frame is open store bytes in order. A write to index 0 with bit 1 set, while a frame is open and bit 0 is clear, closes the frame. The fabric then sees fab_rx_valid=1, fab_rx_len equal to the bytes stored, and each stored byte on fab_rx_rdata at its address.
- R4: A fab_rx_done pulse while a frame is held frees the buffer and raises rx_ready again. Until then, the held length and bytes stay unchanged. Data writes while no frame is open are ignored.
- R5: A data write beyond MAX_LEN bytes is dropped and sets the sticky overflow bit 7 of the receive-control register. Writing index 0 with bit 2 set clears it. Receive-control reads are {overflow, 0000, held, open, rx_ready}.
- R6: The fabric queues up to SLOTS frames. fab_tx_full is 1 exactly when SLOTS frames are waiting, and fabric writes are then ignored. tx_ready is 1 while at least one complete frame is waiting.
- R7: The transmit-control register reads {waiting, at first byte, at last byte, 00, length[10:8]}. Index 3 reads length[7:0] of the oldest waiting frame, and 0 when none is waiting.
- R8: Host reads of the data register return the oldest frame's bytes in order. Reading its last byte releases the slot and moves to the next frame in arrival order.
- R9: While host_dma is 1, host_addr is ignored and both reads and writes address the data register.
- R10: A data read with no frame waiting returns 0 and changes nothing. Writes to indexes 1 and 3 have no effect.
- R11: Bytes a fabric frame carries beyond MAX_LEN are dropped, and the frame is queued with length MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_dma | input | 1 | DMA select; steers accesses to the data register |
| host_addr | input | 2 | Register index (0 rx control, 1 tx control, 2 data, 3 tx length) |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte of the addressed register (combinational) |
| rx_ready | output | 1 | A frame of up to MAX_LEN bytes can be written |
| tx_ready | output | 1 | At least one complete frame waits for the host |
| fab_rx_valid | output | 1 | A closed host frame is held for the fabric |
| fab_rx_len | output | LEN_W (11) | Length of the held frame |
| fab_rx_raddr | input | ADR_W (11) | Fabric byte address into the held frame |
| fab_rx_rdata | output | 8 | Byte at fab_rx_raddr |
| fab_rx_done | input | 1 | Fabric has taken the held frame |
| fab_tx_wr | input | 1 | Fabric byte write into the queue |
| fab_tx_data | input | 8 | Fabric byte |
| fab_tx_last | input | 1 | Marks the final byte of a fabric frame |
| fab_tx_full | output | 1 | All frame slots are occupied |

## Verification
The bench uses six-byte frames and three slots. On the receive side, it sweeps every frame length from empty to full. Each byte carries a value that depends on both the length and its position, so a dropped, repeated or reordered byte shows up in the readback. Frames longer than the limit, restarts and opens refused while a frame is held are what separate the overflow, restart and hold behaviour from plain storage. On the transmit side, frames of each length fill the queue to full. They are drained through both the register path and the DMA path, with the first-byte and last-byte flags checked before every byte. An oversize fabric frame, writes to read-only indexes and empty-queue reads confirm that these inputs change nothing.

// File: rtl/mfp_pkg.sv
`timescale 1ns/1ps
package mfp_pkg;

    typedef enum logic [1:0] {
        SEL_RXCTL = 2'd0,
        SEL_TXCTL = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_TXLEN = 2'd3
    } win_sel_e;

    typedef enum logic [1:0] {
        HOLD_FREE = 2'd0,
        HOLD_OPEN = 2'd1,
        HOLD_FULL = 2'd2
    } rx_phase_e;

    localparam int CTL_OPEN  = 0;
    localparam int CTL_CLOSE = 1;
    localparam int CTL_CLEAR = 2;

    typedef struct packed {
        logic ovf;
        logic held;
        logic open;
        logic ready;
    } rx_flags_t;

    typedef struct packed {
        logic waiting;
        logic first;
        logic last;
    } tx_flags_t;

    function automatic win_sel_e pick_window(input logic dma, input logic [1:0] pins);
        return dma ? SEL_DATA : win_sel_e'(pins);
    endfunction

    function automatic logic [7:0] rx_status_byte(input rx_flags_t f);
        return {f.ovf, 4'b0000, f.held, f.open, f.ready};
    endfunction

    function automatic logic [7:0] tx_status_byte(input tx_flags_t f, input logic [10:0] len);
        return {f.waiting, f.first, f.last, 2'b00, len[10:8]};
    endfunction

endpackage

// File: rtl/mfp_rx_buf.sv
`timescale 1ns/1ps
module mfp_rx_buf
    import mfp_pkg::*;
#(
    parameter  int MAX_LEN = 1535,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int ADR_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic             data_wr,
    input  logic [7:0]       wdata,
    input  logic [ADR_W-1:0] fab_raddr,
    input  logic             fab_done,
    output rx_flags_t        flags,
    output logic             fab_valid,
    output logic [LEN_W-1:0] fab_len,
    output logic [7:0]       fab_rdata
);
    logic [7:0]       store [MAX_LEN];
    rx_phase_e        phase;
    logic [LEN_W-1:0] wptr;
    logic [LEN_W-1:0] len_q;
    logic             ovf_q;
    logic             room;
    logic             take;

    assign room = (wptr < LEN_W'(MAX_LEN));
    assign take = data_wr && (phase == HOLD_OPEN);

    always_ff @(posedge clk) begin
        if (take && room) begin
            store[wptr[ADR_W-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= HOLD_FREE;
            wptr  <= '0;
            len_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (ctl_wr) begin
                if (wdata[CTL_OPEN] && phase != HOLD_FULL) begin
                    phase <= HOLD_OPEN;
                    wptr  <= '0;
                end else if (wdata[CTL_CLOSE] && phase == HOLD_OPEN) begin
                    phase <= HOLD_FULL;
                    len_q <= wptr;
                end
                if (wdata[CTL_CLEAR]) begin
                    ovf_q <= 1'b0;
                end
            end else if (take) begin
                if (room) begin
                    wptr <= wptr + LEN_W'(1);
                end else begin
                    ovf_q <= 1'b1;
                end
            end
            if (phase == HOLD_FULL && fab_done) begin
                phase <= HOLD_FREE;
            end
        end
    end

    assign flags.ovf   = ovf_q;
    assign flags.held  = (phase == HOLD_FULL);
    assign flags.open  = (phase == HOLD_OPEN);
    assign flags.ready = (phase == HOLD_FREE);
    assign fab_valid   = (phase == HOLD_FULL);
    assign fab_len     = len_q;
    assign fab_rdata   = store[fab_raddr];

    AST_RX_WPTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        wptr <= LEN_W'(MAX_LEN)); // R5
    AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q && !(ctl_wr && wdata[CTL_CLEAR]) |=> ovf_q); // R5
    AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (phase == HOLD_FULL) && !fab_done |=> (phase == HOLD_FULL) && $stable(len_q)); // R4
    AST_RX_OPEN_LOWERS_READY: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && wdata[CTL_OPEN] && (phase == HOLD_FREE) |=> !flags.ready); // R2
endmodule

// File: rtl/mfp_tx_queue.sv
`timescale 1ns/1ps
module mfp_tx_queue
    import mfp_pkg::*;
#(
    parameter  int MAX_LEN = 1535,
    parameter  int SLOTS   = 2,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int ADR_W   = $clog2(MAX_LEN),
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fab_wr,
    input  logic [7:0]       fab_data,
    input  logic             fab_last,
    input  logic             host_pop,
    output logic             fab_full,
    output tx_flags_t        flags,
    output logic [LEN_W-1:0] cur_len,
    output logic [7:0]       rdata
);
    logic [7:0]        slot_mem [SLOTS][MAX_LEN];
    logic [LEN_W-1:0]  lens [SLOTS];
    logic [SLOT_W-1:0] head, tail;
    logic [CNT_W-1:0]  count;
    logic [LEN_W-1:0]  wlen, rptr, head_len;
    logic              push_ok, commit, pop_any, pop_last, avail;

    assign avail    = (count != '0);
    assign head_len = lens[head];
    assign push_ok  = fab_wr && (count != CNT_W'(SLOTS));
    assign commit   = push_ok && fab_last;
    assign pop_any  = host_pop && avail;
    assign pop_last = pop_any && (rptr == head_len - LEN_W'(1));

    function automatic logic [SLOT_W-1:0] step(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(SLOTS - 1)) ? '0 : p + SLOT_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && wlen < LEN_W'(MAX_LEN)) begin
            slot_mem[tail][wlen[ADR_W-1:0]] <= fab_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            wlen  <= '0;
            rptr  <= '0;
            for (int s = 0; s < SLOTS; s++) begin
                lens[s] <= '0;
            end
        end else begin
            if (push_ok) begin
                if (fab_last) begin
                    wlen       <= '0;
                    lens[tail] <= (wlen < LEN_W'(MAX_LEN)) ? wlen + LEN_W'(1) : LEN_W'(MAX_LEN);
                    tail       <= step(tail);
                end else if (wlen < LEN_W'(MAX_LEN)) begin
                    wlen <= wlen + LEN_W'(1);
                end
            end
            if (pop_any) begin
                rptr <= pop_last ? '0 : rptr + LEN_W'(1);
            end
            if (pop_last) begin
                head <= step(head);
            end
            case ({commit, pop_last})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign fab_full      = (count == CNT_W'(SLOTS));
    assign flags.waiting = avail;
    assign flags.first   = avail && (rptr == '0);
    assign flags.last    = avail && (rptr == head_len - LEN_W'(1));
    assign cur_len       = avail ? head_len : '0;
    assign rdata         = avail ? slot_mem[head][rptr[ADR_W-1:0]] : 8'h00;

    AST_TX_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(SLOTS)); // R6
    AST_TX_READY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit |=> avail); // R6
    AST_TX_RPTR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        avail |-> rptr < head_len); // R8
    AST_TX_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        fab_full && !pop_last |=> $stable(tail) && $stable(wlen)); // R6
endmodule

// File: rtl/mfp_host_port.sv
`timescale 1ns/1ps
module mfp_host_port
    import mfp_pkg::*;
#(
    parameter  int MAX_LEN = 1535,
    parameter  int SLOTS   = 2,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int ADR_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_dma,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             rx_ready,
    output logic             tx_ready,
    output logic             fab_rx_valid,
    output logic [LEN_W-1:0] fab_rx_len,
    input  logic [ADR_W-1:0] fab_rx_raddr,
    output logic [7:0]       fab_rx_rdata,
    input  logic             fab_rx_done,
    input  logic             fab_tx_wr,
    input  logic [7:0]       fab_tx_data,
    input  logic             fab_tx_last,
    output logic             fab_tx_full
);
    win_sel_e         sel;
    rx_flags_t        rx_f;
    tx_flags_t        tx_f;
    logic [LEN_W-1:0] tx_len;
    logic [10:0]      tx_len11;
    logic [7:0]       tx_byte;

    assign sel      = pick_window(host_dma, host_addr);
    assign tx_len11 = 11'(tx_len);

    mfp_rx_buf #(.MAX_LEN(MAX_LEN)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (host_wr && sel == SEL_RXCTL),
        .data_wr   (host_wr && sel == SEL_DATA),
        .wdata     (host_wdata),
        .fab_raddr (fab_rx_raddr),
        .fab_done  (fab_rx_done),
        .flags     (rx_f),
        .fab_valid (fab_rx_valid),
        .fab_len   (fab_rx_len),
        .fab_rdata (fab_rx_rdata)
    );

    mfp_tx_queue #(.MAX_LEN(MAX_LEN), .SLOTS(SLOTS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .fab_wr   (fab_tx_wr),
        .fab_data (fab_tx_data),
        .fab_last (fab_tx_last),
        .host_pop (host_rd && sel == SEL_DATA),
        .fab_full (fab_tx_full),
        .flags    (tx_f),
        .cur_len  (tx_len),
        .rdata    (tx_byte)
    );

    always_comb begin
        unique case (sel)
            SEL_RXCTL: host_rdata = rx_status_byte(rx_f);
            SEL_TXCTL: host_rdata = tx_status_byte(tx_f, tx_len11);
            SEL_DATA:  host_rdata = tx_byte;
            default:   host_rdata = tx_len11[7:0];
        endcase
    end

    assign rx_ready = rx_f.ready;
    assign tx_ready = tx_f.waiting;

    AST_DMA_IGNORES_PINS: assert property (@(posedge clk) disable iff (rst)
        host_dma && host_wr && !rx_f.held |=> !$rose(fab_rx_valid)); // R9
    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rx_ready && fab_rx_valid)); // R4
endmodule

// File: tb/mfp_host_port_test.sv
`timescale 1ns/1ps
module mfp_host_port_test;
    localparam int ML = 6;
    localparam int SL = 3;
    localparam int LW = $clog2(ML + 1);
    localparam int AW = $clog2(ML);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_dma = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]    host_addr = 2'd0;
    logic [7:0]    host_wdata = 8'h00, host_rdata;
    logic          rx_ready, tx_ready, fab_rx_valid, fab_tx_full;
    logic [LW-1:0] fab_rx_len;
    logic [AW-1:0] fab_rx_raddr = '0;
    logic [7:0]    fab_rx_rdata;
    logic          fab_rx_done = 1'b0, fab_tx_wr = 1'b0, fab_tx_last = 1'b0;
    logic [7:0]    fab_tx_data = 8'h00;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    mfp_host_port #(.MAX_LEN(ML), .SLOTS(SL)) uut (
        .clk(clk), .rst(rst), .host_dma(host_dma), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rx_ready(rx_ready), .tx_ready(tx_ready),
        .fab_rx_valid(fab_rx_valid), .fab_rx_len(fab_rx_len),
        .fab_rx_raddr(fab_rx_raddr), .fab_rx_rdata(fab_rx_rdata),
        .fab_rx_done(fab_rx_done), .fab_tx_wr(fab_tx_wr),
        .fab_tx_data(fab_tx_data), .fab_tx_last(fab_tx_last),
        .fab_tx_full(fab_tx_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] a, input logic [7:0] d, input logic dma);
        @(negedge clk);
        host_dma = dma; host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; host_dma = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] a, input logic dma, output logic [7:0] d);
        @(negedge clk);
        host_dma = dma; host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0; host_dma = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_dma = 1'b0; host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic fpush(input int len, input int base);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            fab_tx_wr = 1'b1; fab_tx_data = 8'(base + i); fab_tx_last = (i == len - 1);
            @(posedge clk); #1;
            fab_tx_wr = 1'b0; fab_tx_last = 1'b0;
        end
    endtask

    task automatic fdone();
        @(negedge clk); fab_rx_done = 1'b1;
        @(posedge clk); #1; fab_rx_done = 1'b0;
    endtask

    task automatic drain(input int elen, input int base, input logic dma, input string tag);
        logic [7:0] d;
        peek(2'd3, d);
        chk({tag, " R7 length"}, 32'(d), elen);
        for (int i = 0; i < elen; i++) begin
            peek(2'd1, d);
            chk({tag, " R7 flags"}, 32'(d),
                32'h80 | (i == 0 ? 32'h40 : 0) | (i == elen - 1 ? 32'h20 : 0));
            hrd(dma ? 2'd0 : 2'd2, dma, d);
            chk({tag, " R8 byte"}, 32'(d), (base + i) & 255);
        end
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 rx_ready", 32'(rx_ready), 1);
        chk("R1 tx_ready", 32'(tx_ready), 0);
        chk("R1 fab_rx_valid", 32'(fab_rx_valid), 0);
        chk("R1 fab_tx_full", 32'(fab_tx_full), 0);
        peek(2'd0, d); chk("R1 rxctl", 32'(d), 32'h01);
        peek(2'd1, d); chk("R1 txctl", 32'(d), 32'h00);
        peek(2'd3, d); chk("R1 txlen", 32'(d), 32'h00);

        // R10 empty data read; R4 data write with no open frame
        hrd(2'd2, 1'b0, d); chk("R10 empty read", 32'(d), 0);
        peek(2'd1, d); chk("R10 txctl after empty read", 32'(d), 0);
        hwr(2'd2, 8'h5A, 1'b0);
        hwr(2'd0, 8'h01, 1'b0);
        hwr(2'd0, 8'h02, 1'b0);
        chk("R4 idle write ignored", 32'(fab_rx_len), 0);
        chk("R3 empty frame held", 32'(fab_rx_valid), 1);
        fdone();

        // R2 R3 R4 sweep over every legal length
        for (int L = 0; L <= ML; L++) begin
            logic dma;
            dma = L[0];
            hwr(2'd0, 8'h01, 1'b0);
            chk("R2 ready drops on open", 32'(rx_ready), 0);
            if (L == 3) begin
                hwr(2'd2, 8'hEE, 1'b0);
                hwr(2'd0, 8'h01, 1'b0);
            end
            for (int i = 0; i < L; i++) hwr(dma ? 2'd0 : 2'd2, 8'(L * 16 + i + 1), dma);
            peek(2'd0, d); chk("R5 rxctl open", 32'(d), 32'h02);
            hwr(2'd0, 8'h02, 1'b0);
            chk("R3 valid", 32'(fab_rx_valid), 1);
            chk(dma ? "R9 length via dma" : "R3 length", 32'(fab_rx_len), L);
            chk("R2 ready low while held", 32'(rx_ready), 0);
            hwr(2'd0, 8'h01, 1'b0);
            hwr(2'd2, 8'h77, 1'b0);
            chk("R2 open refused while held", 32'(fab_rx_len), L);
            for (int i = 0; i < L; i++) begin
                @(negedge clk); fab_rx_raddr = AW'(i);
                #1 chk("R3 fabric byte", 32'(fab_rx_rdata), (L * 16 + i + 1) & 255);
            end
            peek(2'd0, d); chk("R4 rxctl held", 32'(d), 32'h04);
            fdone();
            chk("R4 ready after done", 32'(rx_ready), 1);
        end

        // R5 overflow
        hwr(2'd0, 8'h01, 1'b0);
        for (int i = 0; i < ML + 2; i++) hwr(2'd2, 8'(8'hA0 + i), 1'b0);
        peek(2'd0, d); chk("R5 overflow set", 32'(d), 32'h82);
        hwr(2'd0, 8'h02, 1'b0);
        chk("R5 length capped", 32'(fab_rx_len), ML);
        @(negedge clk); fab_rx_raddr = AW'(ML - 1);
        #1 chk("R5 last kept byte", 32'(fab_rx_rdata), 32'hA0 + ML - 1);
        peek(2'd0, d); chk("R5 sticky", 32'(d), 32'h84);
        hwr(2'd0, 8'h04, 1'b0);
        peek(2'd0, d); chk("R5 cleared", 32'(d), 32'h04);
        fdone();

        // R6 queue fill, R10 read-only windows, R8 drain order
        fpush(1, 8'h10);
        fpush(2, 8'h20);
        chk("R6 not full", 32'(fab_tx_full), 0);
        chk("R6 tx_ready", 32'(tx_ready), 1);
        fpush(3, 8'h30);
        chk("R6 full", 32'(fab_tx_full), 1);
        fpush(2, 8'hE0);
        hwr(2'd1, 8'hFF, 1'b0);
        hwr(2'd3, 8'hFF, 1'b0);
        peek(2'd1, d); chk("R10 txctl write ignored", 32'(d), 32'hE0);
        drain(1, 8'h10, 1'b0, "f1");
        chk("R6 not full after release", 32'(fab_tx_full), 0);
        drain(2, 8'h20, 1'b0, "f2");
        drain(3, 8'h30, 1'b0, "f3");
        chk("R6 empty", 32'(tx_ready), 0);

        // R9 drain through DMA path with pins on control index
        fpush(4, 8'h40);
        fpush(5, 8'h50);
        fpush(6, 8'h60);
        drain(4, 8'h40, 1'b1, "R9 f4");
        drain(5, 8'h50, 1'b1, "R9 f5");
        drain(6, 8'h60, 1'b1, "R9 f6");

        // R11 oversize fabric frame
        fpush(ML + 2, 8'h90);
        peek(2'd3, d); chk("R11 capped length", 32'(d), ML);
        drain(ML, 8'h90, 1'b0, "R11");
        hrd(2'd2, 1'b0, d); chk("R10 empty after drain", 32'(d), 0);
        chk("R6 tx_ready low", 32'(tx_ready), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule